// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Core

This block is the timing heart of a system watchdog. Once armed, it counts down a first interval. If software does not service it in time, it emits an early-warning event: either a normal interrupt pulse or a system-management interrupt pulse, chosen by configuration. It then counts down a second, separately programmed interval. If that interval also runs out, the block issues a reboot request and records a sticky "last reset came from the watchdog" flag. Instead of rebooting, it can be set to wrap around and start the first interval again.

Each interval is a preload value multiplied by a prescale of either 2^SLOW_SHIFT or 2^FAST_SHIFT clock cycles per unit. With the default parameters and a 33 MHz clock, this gives roughly 1 kHz or 1 MHz units. Register decoding, unlock sequences and bus protocol belong to the surrounding logic. That logic presents the block with plain write strobes for the following:
- the configuration word
- the control word
- each preload
- a service ("kick") pulse
- a flag-clear pulse

Top module: `wdog2_core`

## Requirements
- R1: After reset all pulse outputs and `prev_reboot` are low and `stage2` is 0. The defaults are: both preloads all ones, slow scale, event kind 0, reboot enabled, counting disabled, free-run off and unlocked.
- R2: A control write that takes the enable from 0 to 1 starts stage one from preload 1. The stage ends `max(P,1) * 2^S` clock edges after the edge that sampled the write, where P is the preload and S is the active shift.
- R3: At the end of stage one, a one-cycle pulse is issued at that same edge according to `cfg_evt_kind`: 0 pulses `irq_pulse`, 2 pulses `smi_pulse`, and 1 or 3 issue no pulse. Also at that edge `stage2` becomes 1 and stage two starts from preload 2.
- R4: If reboot is enabled when stage two ends, `reboot_req` pulses for one cycle and `prev_reboot` is set at the same edge.
- R5: A reboot returns the configuration, the control word (enable, free-run, lock) and both preloads to their R1 defaults, stops counting and sets `stage2` to 0.
- R6: If stage two ends with reboot disabled and free-run off, no pulse is issued, `stage2` stays 1 and counting halts.
- R7: If stage two ends with reboot disabled and free-run on, stage one restarts from preload 1 at that edge (`stage2` falls to 0).
- R8: A kick while enabled restarts stage one from preload 1 from any state, including after an R6 halt. A kick while disabled has no effect.
- R9: A control write with enable 0 stops counting, and no further events occur.
- R10: While the lock bit is set, control writes are ignored; only reset or a reboot clears the lock. Configuration and preload writes are still accepted.
- R11: A kick or a disabling control write sampled at the same edge as an expiry takes precedence: no event is issued.
- R12: `prev_reboot` stays set across the reboot defaults of R5 and is cleared only by `clr_prev` or reset.
- R13: `cfg_fast` = 1 selects 2^FAST_SHIFT cycles per preload unit; 0 selects 2^SLOW_SHIFT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (nominally 33 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_reboot_en | input | 1 | Issue a reboot on stage-two expiry |
| cfg_fast | input | 1 | 1 = fast prescale, 0 = slow prescale |
| cfg_evt_kind | input | 2 | Stage-one event: 0 irq, 2 smi, 1/3 none |
| ctl_we | input | 1 | Write strobe for the control word (ignored while locked) |
| ctl_enable | input | 1 | Counting enable |
| ctl_free_run | input | 1 | Restart stage one after stage-two expiry |
| ctl_lock | input | 1 | Freeze the control word until reset or reboot |
| ld1_we | input | 1 | Write strobe for preload 1 |
| ld2_we | input | 1 | Write strobe for preload 2 |
| ld_value | input | PRELOAD_W | Preload data |
| kick | input | 1 | Service pulse that restarts stage one |
| clr_prev | input | 1 | Clear the previous-reboot flag |
| irq_pulse | output | 1 | One-cycle normal interrupt event |
| smi_pulse | output | 1 | One-cycle system-management interrupt event |
| reboot_req | output | 1 | One-cycle reboot request |
| stage2 | output | 1 | 1 while in stage two |
| prev_reboot | output | 1 | Sticky: the last reboot came from this block |

## Verification
The critical coincidence is an expiry landing on the same edge as a kick or a disabling control write. The bench first starts stage one, then counts edges to the exact expiry edge and drives the kick, or the disable, so that it is sampled on that edge. It then expects no event and `stage2` at 0 one step after the edge. For the kick, it also expects a full fresh stage-one interval measured from that edge. For the disable, it expects silence afterwards.

// File: rtl/wdog2_pkg.sv
package wdog2_pkg;

  typedef enum logic [1:0] {
    EVK_IRQ   = 2'd0,
    EVK_SPARE = 2'd1,
    EVK_SMI   = 2'd2,
    EVK_QUIET = 2'd3
  } evt_kind_e;

  typedef struct packed {
    logic      reboot_en;
    logic      fast;
    evt_kind_e kind;
  } wd_cfg_t;

  typedef struct packed {
    logic lock;
    logic free_run;
    logic enable;
  } wd_ctl_t;

  typedef struct packed {
    logic irq;
    logic smi;
  } evt_sel_t;

  localparam wd_cfg_t CFG_RESET = '{reboot_en: 1'b1, fast: 1'b0, kind: EVK_IRQ};
  localparam wd_ctl_t CTL_RESET = '{lock: 1'b0, free_run: 1'b0, enable: 1'b0};

  // Map the configured event kind onto the two warning lines.
  function automatic evt_sel_t evt_decode(evt_kind_e k);
    evt_sel_t s;
    s = '0;
    case (k)
      EVK_IRQ: s.irq = 1'b1;
      EVK_SMI: s.smi = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/wdog2_prescale.sv
module wdog2_prescale #(
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int PS_W = SLOW_SHIFT;
  localparam logic [PS_W-1:0] FAST_MASK = PS_W'((64'd1 << FAST_SHIFT) - 64'd1);
  localparam logic [PS_W-1:0] SLOW_MASK = '1;

  logic [PS_W-1:0] ps_q;

  // A unit boundary is reached when every bit under the selected mask is set.
  function automatic logic at_boundary(logic [PS_W-1:0] v, logic f);
    logic [PS_W-1:0] m;
    m = f ? FAST_MASK : SLOW_MASK;
    return (v & m) == m;
  endfunction

  assign tick = run && at_boundary(ps_q, fast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ps_q <= '0;
    else if (clear) ps_q <= '0;
    else if (run)   ps_q <= ps_q + 1'b1;
  end
endmodule

// File: rtl/wdog2_stage_ctr.sv
module wdog2_stage_ctr #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '1;
    else if (load)                   cnt_q <= load_val;
    else if (dec && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  // Zero is treated as one unit so that every stage lasts at least one tick.
  assign last = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/wdog2_ctl.sv
module wdog2_ctl
  import wdog2_pkg::*;
#(
  parameter int PRELOAD_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  wd_cfg_t              cfg_in,
  input  logic                 ctl_we,
  input  wd_ctl_t              ctl_in,
  input  logic                 ld1_we,
  input  logic                 ld2_we,
  input  logic [PRELOAD_W-1:0] ld_value,
  input  logic                 kick,
  input  logic                 clr_prev,
  input  logic                 tick,
  input  logic                 last,
  output logic                 running,
  output logic                 fast,
  output logic                 load,
  output logic [PRELOAD_W-1:0] load_val,
  output logic                 irq_pulse,
  output logic                 smi_pulse,
  output logic                 reboot_req,
  output logic                 stage2,
  output logic                 prev_reboot,
  output logic                 ctl_enabled
);
  localparam logic [PRELOAD_W-1:0] PL_RESET = '1;

  wd_cfg_t               cfg_q;
  wd_ctl_t               ctl_q;
  logic [PRELOAD_W-1:0]  pl1_q, pl2_q;
  logic                  stage_q, run_q, prev_q;
  logic                  irq_q, smi_q, rbt_q;

  logic     ctl_ok, stop, start, kick_ok, expire, pre_empt;
  logic     exp1, exp2, boot, wrap, restart1, halt;
  evt_sel_t sel;

  always_comb begin
    ctl_ok   = ctl_we && !ctl_q.lock;
    stop     = ctl_ok && !ctl_in.enable;
    start    = ctl_ok && ctl_in.enable && !ctl_q.enable;
    kick_ok  = kick && ctl_q.enable;
    expire   = run_q && tick && last;
    pre_empt = stop || start || kick_ok;
    exp1     = expire && !pre_empt && !stage_q;
    exp2     = expire && !pre_empt && stage_q;
    boot     = exp2 && cfg_q.reboot_en;
    wrap     = exp2 && !cfg_q.reboot_en && ctl_q.free_run;
    restart1 = (!stop && (start || kick_ok)) || wrap;
    halt     = stop || (exp2 && !wrap);
    sel      = evt_decode(cfg_q.kind);
  end

  assign load     = restart1 || exp1;
  assign load_val = exp1 ? pl2_q : pl1_q;
  assign running  = run_q;
  assign fast     = cfg_q.fast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RESET;
      ctl_q   <= CTL_RESET;
      pl1_q   <= PL_RESET;
      pl2_q   <= PL_RESET;
      stage_q <= 1'b0;
      run_q   <= 1'b0;
      prev_q  <= 1'b0;
    end else if (boot) begin
      cfg_q   <= CFG_RESET;
      ctl_q   <= CTL_RESET;
      pl1_q   <= PL_RESET;
      pl2_q   <= PL_RESET;
      stage_q <= 1'b0;
      run_q   <= 1'b0;
      prev_q  <= 1'b1;
    end else begin
      if (cfg_we) cfg_q <= cfg_in;
      if (ctl_ok) ctl_q <= ctl_in;
      if (ld1_we) pl1_q <= ld_value;
      if (ld2_we) pl2_q <= ld_value;
      if (restart1) begin
        stage_q <= 1'b0;
        run_q   <= 1'b1;
      end else if (exp1) begin
        stage_q <= 1'b1;
      end else if (halt) begin
        run_q   <= 1'b0;
      end
      if (clr_prev) prev_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      smi_q <= 1'b0;
      rbt_q <= 1'b0;
    end else begin
      irq_q <= exp1 && sel.irq;
      smi_q <= exp1 && sel.smi;
      rbt_q <= boot;
    end
  end

  assign irq_pulse   = irq_q;
  assign smi_pulse   = smi_q;
  assign reboot_req  = rbt_q;
  assign stage2      = stage_q;
  assign prev_reboot = prev_q;
  assign ctl_enabled = ctl_q.enable;
endmodule

// File: rtl/wdog2_core.sv
module wdog2_core
  import wdog2_pkg::*;
#(
  parameter int PRELOAD_W  = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_reboot_en,
  input  logic                 cfg_fast,
  input  logic [1:0]           cfg_evt_kind,
  input  logic                 ctl_we,
  input  logic                 ctl_enable,
  input  logic                 ctl_free_run,
  input  logic                 ctl_lock,
  input  logic                 ld1_we,
  input  logic                 ld2_we,
  input  logic [PRELOAD_W-1:0] ld_value,
  input  logic                 kick,
  input  logic                 clr_prev,
  output logic                 irq_pulse,
  output logic                 smi_pulse,
  output logic                 reboot_req,
  output logic                 stage2,
  output logic                 prev_reboot
);
  wd_cfg_t cfg_in;
  wd_ctl_t ctl_in;

  // Named internal events, also observed by the bound checker.
  logic                 unit_tick;
  logic                 stage_last;
  logic                 cnt_running;
  logic                 scale_fast;
  logic                 stage_load;
  logic [PRELOAD_W-1:0] stage_load_val;
  logic                 ctl_enabled;

  assign cfg_in = '{reboot_en: cfg_reboot_en, fast: cfg_fast, kind: evt_kind_e'(cfg_evt_kind)};
  assign ctl_in = '{lock: ctl_lock, free_run: ctl_free_run, enable: ctl_enable};

  wdog2_prescale #(
    .SLOW_SHIFT(SLOW_SHIFT),
    .FAST_SHIFT(FAST_SHIFT)
  ) u_prescale (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(stage_load),
    .run  (cnt_running),
    .fast (scale_fast),
    .tick (unit_tick)
  );

  wdog2_stage_ctr #(
    .CNT_W(PRELOAD_W)
  ) u_stage_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (stage_load),
    .load_val(stage_load_val),
    .dec     (unit_tick),
    .last    (stage_last)
  );

  wdog2_ctl #(
    .PRELOAD_W(PRELOAD_W)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_in     (cfg_in),
    .ctl_we     (ctl_we),
    .ctl_in     (ctl_in),
    .ld1_we     (ld1_we),
    .ld2_we     (ld2_we),
    .ld_value   (ld_value),
    .kick       (kick),
    .clr_prev   (clr_prev),
    .tick       (unit_tick),
    .last       (stage_last),
    .running    (cnt_running),
    .fast       (scale_fast),
    .load       (stage_load),
    .load_val   (stage_load_val),
    .irq_pulse  (irq_pulse),
    .smi_pulse  (smi_pulse),
    .reboot_req (reboot_req),
    .stage2     (stage2),
    .prev_reboot(prev_reboot),
    .ctl_enabled(ctl_enabled)
  );
endmodule

// File: rtl/wdog2_core_chk.sv
module wdog2_core_chk (
  input logic clk,
  input logic rst_n,
  input logic kick,
  input logic ctl_we,
  input logic clr_prev,
  input logic ctl_enabled,
  input logic irq_pulse,
  input logic smi_pulse,
  input logic reboot_req,
  input logic stage2,
  input logic prev_reboot
);
  // R3: at most one event line at a time
  a_r3_evt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_pulse, smi_pulse, reboot_req}));

  // R3: warning pulses last one cycle
  a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  a_r3_smi_single: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |=> !smi_pulse);

  // R3: a warning coincides with entry into stage two
  a_r3_stage_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse || smi_pulse) |-> (stage2 && !$past(stage2)));

  // R4 and R5: reboot leaves stage two, sets the flag and disarms
  a_r5_reboot_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |-> (!stage2 && prev_reboot && !ctl_enabled && $past(stage2)));

  // R8: a kick while enabled returns to stage one without any event
  a_r8_kick_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && ctl_enabled && !ctl_we) |=> (!stage2 && !irq_pulse && !smi_pulse && !reboot_req));

  // R9: a disarmed core stays silent
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enabled |=> (!irq_pulse && !smi_pulse && !reboot_req));

  // R12: the flag only falls on an explicit clear
  a_r12_prev_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_reboot && !clr_prev) |=> prev_reboot);
endmodule

bind wdog2_core wdog2_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .kick       (kick),
  .ctl_we     (ctl_we),
  .clr_prev   (clr_prev),
  .ctl_enabled(ctl_enabled),
  .irq_pulse  (irq_pulse),
  .smi_pulse  (smi_pulse),
  .reboot_req (reboot_req),
  .stage2     (stage2),
  .prev_reboot(prev_reboot)
);

// File: tb/test_wdog2_core.sv
module test_wdog2_core;
  localparam int PW     = 4;
  localparam int SS     = 4;
  localparam int FS     = 1;
  localparam int SLOW_U = 1 << SS;
  localparam int FAST_U = 1 << FS;
  localparam int PMAX   = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_reboot_en, cfg_fast;
  logic [1:0] cfg_evt_kind;
  logic ctl_we, ctl_enable, ctl_free_run, ctl_lock;
  logic ld1_we, ld2_we;
  logic [PW-1:0] ld_value;
  logic kick, clr_prev;
  logic irq_pulse, smi_pulse, reboot_req, stage2, prev_reboot;

  wdog2_core #(.PRELOAD_W(PW), .SLOW_SHIFT(SS), .FAST_SHIFT(FS)) i_wdog2_core (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_reboot_en(cfg_reboot_en), .cfg_fast(cfg_fast), .cfg_evt_kind(cfg_evt_kind),
    .ctl_we(ctl_we), .ctl_enable(ctl_enable), .ctl_free_run(ctl_free_run), .ctl_lock(ctl_lock),
    .ld1_we(ld1_we), .ld2_we(ld2_we), .ld_value(ld_value),
    .kick(kick), .clr_prev(clr_prev),
    .irq_pulse(irq_pulse), .smi_pulse(smi_pulse), .reboot_req(reboot_req),
    .stage2(stage2), .prev_reboot(prev_reboot)
  );

  always #4 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check_eq(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int units(int p);
    return (p == 0) ? 1 : p;
  endfunction

  // Each write is driven at a falling edge, sampled at the next rising edge,
  // and released 1 ns after it; the task returns just after that edge.
  task automatic wr_cfg(bit rb, bit f, int kind);
    @(negedge clk);
    cfg_we = 1; cfg_reboot_en = rb; cfg_fast = f; cfg_evt_kind = 2'(kind);
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic wr_ctl(bit en, bit fr, bit lk);
    @(negedge clk);
    ctl_we = 1; ctl_enable = en; ctl_free_run = fr; ctl_lock = lk;
    @(posedge clk); #1 ctl_we = 0;
  endtask

  task automatic wr_ld(int which, int val);
    @(negedge clk);
    ld_value = PW'(val);
    if (which == 1) ld1_we = 1; else ld2_we = 1;
    @(posedge clk); #1 ld1_we = 0; ld2_we = 0;
  endtask

  task automatic do_kick();
    @(negedge clk); kick = 1;
    @(posedge clk); #1 kick = 0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr_prev = 1;
    @(posedge clk); #1 clr_prev = 0;
  endtask

  // Counts rising edges until a pulse or a stage change; ev: 1 irq, 2 smi, 4 reboot.
  task automatic wait_evt(int maxc, output int k, output int ev);
    logic s0;
    bit found;
    s0 = stage2; k = 0; ev = 0; found = 0;
    for (int i = 1; i <= maxc && !found; i++) begin
      @(posedge clk); #1;
      if (irq_pulse || smi_pulse || reboot_req || stage2 != s0) begin
        found = 1; k = i;
        ev = (irq_pulse ? 1 : 0) + (smi_pulse ? 2 : 0) + (reboot_req ? 4 : 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int k, ev;
    rst_n = 0;
    cfg_we = 0; cfg_reboot_en = 0; cfg_fast = 0; cfg_evt_kind = 0;
    ctl_we = 0; ctl_enable = 0; ctl_free_run = 0; ctl_lock = 0;
    ld1_we = 0; ld2_we = 0; ld_value = 0; kick = 0; clr_prev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    check_eq("R1 irq after reset", irq_pulse, 0);
    check_eq("R1 smi after reset", smi_pulse, 0);
    check_eq("R1 reboot after reset", reboot_req, 0);
    check_eq("R1 stage after reset", stage2, 0);
    check_eq("R1 prev after reset", prev_reboot, 0);

    // R1, R2, R13 defaults: slow scale, full preloads, irq kind, reboot on
    wr_ctl(1, 0, 0);
    wait_evt(400, k, ev);
    check_eq("R2 default stage-one length", k, PMAX * SLOW_U);
    check_eq("R1 default kind irq", ev, 1);
    check_eq("R3 stage2 after warning", stage2, 1);
    wait_evt(400, k, ev);
    check_eq("R4 default stage-two length", k, PMAX * SLOW_U);
    check_eq("R4 reboot pulse", ev, 4);
    check_eq("R4 prev set", prev_reboot, 1);
    check_eq("R5 stage one after reboot", stage2, 0);
    wait_evt(600, k, ev);
    check_eq("R5 stopped after reboot", k, 0);

    // R5: reboot restores configuration and preloads
    wr_cfg(1, 1, 2); wr_ld(1, 3); wr_ld(2, 2);
    wr_ctl(1, 0, 0);
    wait_evt(100, k, ev);
    check_eq("R13 fast stage-one length", k, 3 * FAST_U);
    check_eq("R3 smi kind", ev, 2);
    wait_evt(100, k, ev);
    check_eq("R4 fast stage-two length", k, 2 * FAST_U);
    check_eq("R4 reboot pulse fast", ev, 4);
    wr_ctl(1, 0, 0);
    wait_evt(400, k, ev);
    check_eq("R5 scale and preload reverted", k, PMAX * SLOW_U);
    check_eq("R5 kind reverted", ev, 1);
    wr_ctl(0, 0, 0);
    wait_evt(600, k, ev);
    check_eq("R9 disable stops", k, 0);
    check_eq("R12 prev sticky across defaults", prev_reboot, 1);
    do_clr();
    check_eq("R12 prev cleared", prev_reboot, 0);

    // R2, R3, R7, R13 sweep: every preload, every kind, free-run wrap
    wr_cfg(0, 1, 0);
    for (int kind = 0; kind < 4; kind++) begin
      wr_cfg(0, 1, kind);
      for (int p1 = 0; p1 <= PMAX; p1++) begin
        int p2;
        int exp_ev;
        p2 = (p1 * 5 + 3) % (PMAX + 1);
        exp_ev = (kind == 0) ? 1 : ((kind == 2) ? 2 : 0);
        wr_ld(1, p1); wr_ld(2, p2);
        wr_ctl(1, 1, 0);
        wait_evt(200, k, ev);
        check_eq("R2 sweep stage-one length", k, units(p1) * FAST_U);
        check_eq("R3 sweep event kind", ev, exp_ev);
        wait_evt(200, k, ev);
        check_eq("R7 sweep stage-two length", k, units(p2) * FAST_U);
        check_eq("R7 sweep wrap silent", ev, 0);
        check_eq("R7 sweep back to stage one", stage2, 0);
        wr_ctl(0, 1, 0);
      end
    end

    // R6 halt, then R8 kick revives it
    wr_cfg(0, 1, 0); wr_ld(1, 2); wr_ld(2, 3);
    wr_ctl(1, 0, 0);
    wait_evt(100, k, ev);
    check_eq("R6 warning before halt", ev, 1);
    wait_evt(60, k, ev);
    check_eq("R6 no event on final expiry", k, 0);
    check_eq("R6 stage stays two", stage2, 1);
    do_kick();
    check_eq("R8 kick returns to stage one", stage2, 0);
    wait_evt(100, k, ev);
    check_eq("R8 interval after kick", k, 2 * FAST_U);
    // R8 kick in mid stage one
    repeat (2) @(posedge clk);
    wr_ctl(0, 0, 0);
    wr_ctl(1, 0, 0);
    @(posedge clk);
    do_kick();
    wait_evt(100, k, ev);
    check_eq("R8 mid-stage kick restarts", k, 2 * FAST_U);
    wr_ctl(0, 0, 0);
    do_kick();
    wait_evt(60, k, ev);
    check_eq("R8 kick ignored while disabled", k, 0);

    // R10 lock
    wr_ctl(1, 0, 1);
    wr_ctl(0, 0, 0);
    wait_evt(100, k, ev);
    check_eq("R10 disable ignored while locked", k, 2 * FAST_U - 1);
    check_eq("R10 warning while locked", ev, 1);
    wr_cfg(1, 1, 0);
    wait_evt(100, k, ev);
    check_eq("R10 cfg accepted while locked", k, 3 * FAST_U - 1);
    check_eq("R10 reboot clears lock", ev, 4);
    wr_ctl(1, 0, 0);
    wr_ctl(0, 0, 0);
    wait_evt(600, k, ev);
    check_eq("R10 unlocked after reboot", k, 0);

    // R11 kick on the expiry edge
    wr_cfg(0, 1, 0); wr_ld(1, 3); wr_ld(2, 3);
    wr_ctl(1, 0, 0);
    repeat (3 * FAST_U - 1) @(posedge clk);
    do_kick();
    check_eq("R11 kick beats expiry event", irq_pulse, 0);
    check_eq("R11 kick beats expiry stage", stage2, 0);
    wait_evt(100, k, ev);
    check_eq("R11 fresh interval after kick", k, 3 * FAST_U);
    wr_ctl(0, 0, 0);
    // R11 disable on the expiry edge
    wr_ctl(1, 0, 0);
    repeat (3 * FAST_U - 1) @(posedge clk);
    wr_ctl(0, 0, 0);
    check_eq("R11 disable beats expiry event", irq_pulse, 0);
    check_eq("R11 disable beats expiry stage", stage2, 0);
    wait_evt(60, k, ev);
    check_eq("R11 silent after disable", k, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule